// File: doc/BRIEF.md
# Four-Lane Integer Vector ALU

This unit performs one integer operation across a vector of four 32-bit lanes, named x, y, z and w. A request arrives as an opcode together with three source vectors, and a qualifying strobe marks it valid. The unit captures the result for every lane in its output register on the next rising clock edge. It raises its own valid strobe in that same cycle. The destination register keeps its value until the next valid request arrives.

The operations are these:
- Bitwise complement, AND, OR and XOR.
- Logical shifts left and right. A single shift count applies to every lane.
- Unsigned remainder.
- Two's-complement absolute value.
- Absolute difference with an accumulate.
- A per-lane select that picks an operand according to whether a test lane is nonzero.

A shader-style integer datapath uses the unit as a single-cycle execution stage.

Top module: `vec4_int_alu`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `dst` is all zero until the first valid request.
- R2: `out_valid` equals the `in_valid` of the previous clock edge. `dst` loads the result at the edge where `in_valid` is 1. When `in_valid` is 0, `dst` holds its value whatever the opcode and sources are.
- R3: Each vector packs lane x at bits 31:0, lane y at bits 63:32, lane z at bits 95:64 and lane w at bits 127:96. The bitwise opcodes work lane by lane, as follows:
  - opcode 0 gives ~src0.
  - opcode 1 gives src0 & src1.
  - opcode 2 gives src0 | src1.
  - opcode 3 gives src0 ^ src1.
- R4: Opcodes 4 (shift left) and 5 (shift right) shift every lane of src0 by the count in bits 4:0 of src1 lane x. The other lanes of src1 and the upper bits of lane x are ignored. The right shift fills with zeros.
- R5: Opcode 6 gives the unsigned src0_i mod src1_i in each lane. A zero divisor gives 0 in that lane.
- R6: Opcode 7 gives the two's-complement absolute value of src0 in each lane. The value 0x80000000 maps to itself.
- R7: Opcode 8 gives |src0_i − src1_i| + src2_i in each lane. The difference is taken on unsigned values, and the sum wraps modulo 2^32.
- R8: Opcode 9 gives src1_i in each lane where src0_i is nonzero, and src2_i where it is zero.
- R9: Opcodes 10 to 15 give an all-zero `dst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| src0 | input | 128 | First source vector |
| src1 | input | 128 | Second source vector |
| src2 | input | 128 | Third source vector |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dst | output | 128 | Registered destination vector |

## Verification
Every operation has exactly one cycle of latency. A request presented before a rising edge shows up on `dst` and `out_valid` right after that edge, and nothing lags by more than one edge. The bench therefore advances its reference model at the same rising edge the design uses: a valid flag, plus a held result vector updated only on valid requests. It compares both outputs at every falling edge, so each result is checked exactly one edge after its request. Idle cycles with varying junk inputs are checked the same way, which confirms that the held value does not move.

// File: rtl/vec4_int_alu.sv
module vec4_int_alu #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int OP_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [OP_W-1:0]           op,
  input  logic [LANES*LANE_W-1:0]   src0,
  input  logic [LANES*LANE_W-1:0]   src1,
  input  logic [LANES*LANE_W-1:0]   src2,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   dst
);
  localparam int VW   = LANES * LANE_W;
  localparam int SH_W = $clog2(LANE_W);

  localparam logic [OP_W-1:0] OP_NOT  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_AND  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_OR   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_XOR  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_SHL  = OP_W'(4);
  localparam logic [OP_W-1:0] OP_SHR  = OP_W'(5);
  localparam logic [OP_W-1:0] OP_MOD  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_IABS = OP_W'(7);
  localparam logic [OP_W-1:0] OP_SAD  = OP_W'(8);
  localparam logic [OP_W-1:0] OP_SEL  = OP_W'(9);

  logic [SH_W-1:0] shamt;
  logic [VW-1:0]   res;

  assign shamt = src1[SH_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a, b, c, diff, r;
    assign a = src0[i*LANE_W +: LANE_W];
    assign b = src1[i*LANE_W +: LANE_W];
    assign c = src2[i*LANE_W +: LANE_W];
    assign diff = (a >= b) ? (a - b) : (b - a);

    always_comb begin
      case (op)
        OP_NOT:  r = ~a;
        OP_AND:  r = a & b;
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SHL:  r = a << shamt;
        OP_SHR:  r = a >> shamt;
        OP_MOD:  r = (b == '0) ? '0 : (a % b);
        OP_IABS: r = a[LANE_W-1] ? ('0 - a) : a;
        OP_SAD:  r = diff + c;
        OP_SEL:  r = (|a) ? b : c;
        default: r = '0;
      endcase
    end

    assign res[i*LANE_W +: LANE_W] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= res;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst));

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_SEL) |=> dst == '0);

  // R3
  not_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NOT) |=> dst == ~$past(src0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && dst == '0));
endmodule

// File: tb/tb_vec4_int_alu.sv
module tb_vec4_int_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [127:0] src0 = '0, src1 = '0, src2 = '0;
  logic         out_valid;
  logic [127:0] dst;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  logic         exp_v = 1'b0;
  logic [127:0] exp_d = '0;

  vec4_int_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src0(src0), .src1(src1), .src2(src2),
    .out_valid(out_valid), .dst(dst)
  );

  always #10 clk = ~clk;

  function automatic logic [127:0] model(input int code, input logic [127:0] a,
                                         input logic [127:0] b, input logic [127:0] c);
    logic [127:0] o;
    int unsigned  cnt;
    cnt = b[4:0];
    for (int i = 0; i < 4; i++) begin
      int unsigned x, y, z, v;
      int          s;
      x = a[32*i +: 32];
      y = b[32*i +: 32];
      z = c[32*i +: 32];
      s = a[32*i +: 32];
      case (code)
        0: v = ~x;
        1: v = x & y;
        2: v = x | y;
        3: v = x ^ y;
        4: v = x << cnt;
        5: v = x >> cnt;
        6: v = (y == 0) ? 0 : x % y;
        7: v = (s < 0) ? -s : s;
        8: v = ((x > y) ? x - y : y - x) + z;
        9: v = (x != 0) ? y : z;
        default: v = 0;
      endcase
      o[32*i +: 32] = v;
    end
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
      exp_d <= '0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) exp_d <= model(int'(op), src0, src1, src2);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v || dst !== exp_d) begin
        errors++;
        $display("FAIL %s: out_valid=%0b dst=%h expected out_valid=%0b dst=%h",
                 tag, out_valid, dst, exp_v, exp_d);
      end
    end
  end

  task automatic issue(input string t, input int code, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c);
    @(negedge clk);
    tag = t; in_valid = 1'b1; op = code[3:0]; src0 = a; src1 = b; src2 = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3
    issue("R3", 0, {32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_0F0F}, '0, '0);
    issue("R3", 1, {32'hF0F0_F0F0, 32'hFFFF_0000, 32'h1, 32'h8000_0001},
                   {32'h0FF0_0FF0, 32'h00FF_FF00, 32'h3, 32'hFFFF_FFFF}, '0);
    issue("R3", 2, {32'hF000_0000, 32'h0, 32'h1, 32'h8000_0000},
                   {32'h000F_0000, 32'h0, 32'h2, 32'h7FFF_FFFF}, '0);
    issue("R3", 3, {32'hFFFF_FFFF, 32'h1234_5678, 32'h0, 32'hAAAA_AAAA},
                   {32'h0F0F_0F0F, 32'h1234_5678, 32'h5, 32'h5555_5555}, '0);
    // R4: count 33 keeps only 1; other src1 lanes ignored
    issue("R4", 4, {32'h8000_0001, 32'h1, 32'h4000_0000, 32'hFFFF_FFFF},
                   {32'hDEAD_BEEF, 32'h7, 32'h9, 32'h21}, '0);
    issue("R4", 5, {32'h8000_0000, 32'hFFFF_FFFF, 32'h10, 32'h1234_5678},
                   {32'h3, 32'h4, 32'h5, 32'hFFFF_FFE4}, '0);
    issue("R4", 4, {32'h1, 32'h3, 32'h5, 32'h7}, {96'h0, 32'h1F}, '0);
    // R5
    issue("R5", 6, {32'hFFFF_FFFF, 32'h64, 32'h7, 32'h8000_0000},
                   {32'h10, 32'h0, 32'h7, 32'h3}, '0);
    // R6
    issue("R6", 7, {32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h7FFF_FFFF}, '0, '0);
    // R7
    issue("R7", 8, {32'h5, 32'h0, 32'hFFFF_FFFF, 32'h10},
                   {32'h9, 32'hFFFF_FFFF, 32'h0, 32'h10},
                   {32'h1, 32'h2, 32'h1, 32'h7});
    // R8
    issue("R8", 9, {32'h0, 32'h1, 32'h8000_0000, 32'h0},
                   {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
                   {32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD});
    // R9
    issue("R9", 12, {4{32'hFFFF_FFFF}}, {4{32'h1}}, {4{32'h2}});
    issue("R9", 15, {4{32'h1234_5678}}, {4{32'h1}}, {4{32'h2}});
    // R2: result loaded, then idle cycles with junk must not disturb dst
    issue("R2", 2, {4{32'h0F0F_0F0F}}, {4{32'h3030_3030}}, '0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      tag = "R2"; op = k[3:0]; src0 = {4{$urandom}}; src1 = {4{$urandom}};
    end
    // back-to-back requests, R2 through R9 mixed
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      tag = "R2-R9 mix";
      in_valid = ($urandom_range(0, 3) != 0);
      op = 4'($urandom_range(0, 15));
      src0 = {$urandom, $urandom, $urandom, $urandom};
      src1 = {$urandom, $urandom, $urandom, ($urandom_range(0, 1) != 0) ? 32'h0 : $urandom};
      src2 = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 4) == 0) src0[63:32] = 32'h0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R1: reset again mid-run
    @(negedge clk);
    tag = "R1"; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule